// File: doc/BRIEF.md
# Program Sequencer with Branch and Single-Level Call

This unit owns the program address of a small processor. Every cycle it chooses the next address. The choices are the next sequential address, a jump to a register or immediate target, a compare-and-branch on two full-width operands, or a branch on the sign of the most recent arithmetic result. The unit keeps that sign in its own one-bit flag. The decoder only has to mark which operation is arithmetic and supply the sign bit of that result.

A call and a return each take two cycles. In the first cycle of a call, the unit writes the address after the call into a single link register and latches the jump target. In the same cycle it raises `busy_o` so that fetch holds. In the second cycle the program address moves to the latched target. A return follows the same pattern, with the link register as its target. There is only one link register, so a nested call replaces the return point saved by the outer call.

Top module: `pc_sequencer`

## Requirements
- R1: After reset, `pc_o` is 0, `busy_o` is 0, the link register holds 0 and the held sign flag reads as positive.
- R2: Op codes 0 (advance), 1 (arithmetic) and 2 (logic) load `pc_o` with `pc_o`+1. Op codes 14 and 15 do the same. The addition wraps from 4095 to 0.
- R3: Op 3 loads `pc_o` from bits 11:0 of `opa_i`. Op 4 loads it from bits 11:0 of `imm_i`. Bits 15:12 of either source have no effect.
- R4: Op 5 loads bits 11:0 of `imm_i` when all 16 bits of `opa_i` and `opb_i` match. Otherwise it advances by one, even when the operands differ only in bits above 11.
- R5: Ops 6 and 7 jump when the held sign flag is 0, which includes a zero result. Op 6 takes its target from `opa_i` and op 7 from `imm_i`. Ops 8 and 9 jump when the flag is 1, with op 8 taking its target from `opa_i` and op 9 from `imm_i`. A branch that is not taken advances by one.
- R6: The sign flag takes `res_sign_i` only on op 1. On op 2 and on every other op, the flag keeps its value.
- R7: A call is op 10 (target from `opa_i`) or op 11 (target from `imm_i`). In its first cycle, `busy_o` is 1, `pc_o` holds its value, and the link register takes `pc_o`+1. In the next cycle, `pc_o` loads the target captured in the first cycle, and `busy_o` is 0. All inputs in that second cycle are ignored.
- R8: A return is op 12. In its first cycle, `busy_o` is 1 and `pc_o` holds its value. In the next cycle, `pc_o` loads the link register. If no call has happened since reset, that value is 0.
- R9: The link register holds one entry. A second call before a return overwrites it, so the return goes to the address after the most recent call.
- R10: Op 13 (hold) leaves `pc_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Sequencing operation code (see requirements) |
| opa_i | input | 16 | First operand; register jump target and compare input |
| opb_i | input | 16 | Second compare operand |
| imm_i | input | 16 | Immediate target |
| res_sign_i | input | 1 | Sign bit of the arithmetic result retired with op 1 |
| pc_o | output | 12 | Program address |
| busy_o | output | 1 | High in the first cycle of a call or return; fetch must hold |

## Verification
The bench builds the unit with its default widths: a 16-bit operand and a 12-bit address. With a 12-bit address, one immediate jump to 4095 is enough to reach the wrap to 0. The four bits between the address width and the operand width let the bench show two things. Those bits are dropped from jump targets. They still count in the compare-branch, so two operands that share the low 12 bits but differ above them do not branch. The call and return sequences are checked cycle by cycle, including a conflicting jump presented during the second cycle of a call and two nested calls.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [3:0] {
        OP_STEP     = 4'd0,
        OP_ARITH    = 4'd1,
        OP_LOGIC    = 4'd2,
        OP_JMP_REG  = 4'd3,
        OP_JMP_IMM  = 4'd4,
        OP_BR_EQ    = 4'd5,
        OP_BPOS_REG = 4'd6,
        OP_BPOS_IMM = 4'd7,
        OP_BNEG_REG = 4'd8,
        OP_BNEG_IMM = 4'd9,
        OP_CALL_REG = 4'd10,
        OP_CALL_IMM = 4'd11,
        OP_RETURN   = 4'd12,
        OP_HOLD     = 4'd13,
        OP_SPARE0   = 4'd14,
        OP_SPARE1   = 4'd15
    } pc_op_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_LOAD = 1'b1
    } pc_phase_e;

endpackage

// File: rtl/pcseq_sign_flag.sv
module pcseq_sign_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_i,
    input  logic sign_i,
    output logic sign_o
);

    logic sign_d;
    logic sign_q;

    always_comb begin
        sign_d = sign_q;
        if (upd_i) begin
            sign_d = sign_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_q <= 1'b0;
        end else begin
            sign_q <= sign_d;
        end
    end

    assign sign_o = sign_q;

    // R6: without an update strobe the held sign must not move
    assert_sign_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(sign_o));

    // R6: an update strobe captures the offered sign
    assert_sign_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> (sign_o == $past(sign_i)));

endmodule

// File: rtl/pcseq_branch_eval.sv
module pcseq_branch_eval
    import pcseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PC_W   = 12
) (
    input  pc_op_e            op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic              sign_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   link_i,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              pair_o,
    output logic              is_call_o,
    output logic [PC_W-1:0]   pair_tgt_o
);

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] reg_tgt;
    logic [PC_W-1:0] imm_tgt;
    logic            operands_eq;

    assign seq_pc      = pc_i + PC_W'(1);
    assign reg_tgt     = opa_i[PC_W-1:0];
    assign imm_tgt     = imm_i[PC_W-1:0];
    assign operands_eq = (opa_i == opb_i);

    always_comb begin
        next_pc_o  = seq_pc;
        pair_o     = 1'b0;
        is_call_o  = 1'b0;
        pair_tgt_o = link_i;
        unique case (op_i)
            OP_JMP_REG:  next_pc_o = reg_tgt;
            OP_JMP_IMM:  next_pc_o = imm_tgt;
            OP_BR_EQ:    next_pc_o = operands_eq ? imm_tgt : seq_pc;
            OP_BPOS_REG: next_pc_o = !sign_i ? reg_tgt : seq_pc;
            OP_BPOS_IMM: next_pc_o = !sign_i ? imm_tgt : seq_pc;
            OP_BNEG_REG: next_pc_o = sign_i ? reg_tgt : seq_pc;
            OP_BNEG_IMM: next_pc_o = sign_i ? imm_tgt : seq_pc;
            OP_CALL_REG: begin
                next_pc_o  = pc_i;
                pair_o     = 1'b1;
                is_call_o  = 1'b1;
                pair_tgt_o = reg_tgt;
            end
            OP_CALL_IMM: begin
                next_pc_o  = pc_i;
                pair_o     = 1'b1;
                is_call_o  = 1'b1;
                pair_tgt_o = imm_tgt;
            end
            OP_RETURN: begin
                next_pc_o  = pc_i;
                pair_o     = 1'b1;
            end
            OP_HOLD:     next_pc_o = pc_i;
            default:     next_pc_o = seq_pc;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PC_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic              res_sign_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              busy_o
);

    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] link;
        logic [PC_W-1:0] tgt;
        pc_phase_e       phase;
    } seq_regs_t;

    seq_regs_t regs_d;
    seq_regs_t regs_q;

    pc_op_e          op;
    logic            sign_held;
    logic            sign_upd;
    logic [PC_W-1:0] eval_next;
    logic            eval_pair;
    logic            eval_call;
    logic [PC_W-1:0] eval_tgt;

    assign op = pc_op_e'(op_i);

    pcseq_sign_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (sign_upd),
        .sign_i (res_sign_i),
        .sign_o (sign_held)
    );

    pcseq_branch_eval #(
        .DATA_W (DATA_W),
        .PC_W   (PC_W)
    ) u_eval (
        .op_i       (op),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .imm_i      (imm_i),
        .sign_i     (sign_held),
        .pc_i       (regs_q.pc),
        .link_i     (regs_q.link),
        .next_pc_o  (eval_next),
        .pair_o     (eval_pair),
        .is_call_o  (eval_call),
        .pair_tgt_o (eval_tgt)
    );

    always_comb begin
        regs_d   = regs_q;
        busy_o   = 1'b0;
        sign_upd = 1'b0;
        if (regs_q.phase == PH_LOAD) begin
            regs_d.pc    = regs_q.tgt;
            regs_d.phase = PH_IDLE;
        end else begin
            regs_d.pc = eval_next;
            sign_upd  = (op == OP_ARITH);
            if (eval_pair) begin
                busy_o       = 1'b1;
                regs_d.tgt   = eval_tgt;
                regs_d.phase = PH_LOAD;
                if (eval_call) begin
                    regs_d.link = regs_q.pc + PC_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{pc: '0, link: '0, tgt: '0, phase: PH_IDLE};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pc_o = regs_q.pc;

    // R7, R8: the first cycle of a pair leaves the address where it was
    assert_busy_holds_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(pc_o));

    // R7: busy never spans two consecutive cycles
    assert_busy_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o);

    // R7: a call saves the address after itself
    assert_call_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (op == OP_CALL_REG || op == OP_CALL_IMM))
        |=> (regs_q.link == $past(pc_o) + PC_ONE));

    // R8: a return lands on the saved address two cycles later
    assert_return_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op == OP_RETURN) |=> ##1 (pc_o == $past(regs_q.link, 2)));

    // R2: plain advance outside a pair moves by exactly one
    assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.phase == PH_IDLE && op == OP_STEP) |=> (pc_o == $past(pc_o) + PC_ONE));

    // R10: hold outside a pair keeps the address
    assert_hold_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.phase == PH_IDLE && op == OP_HOLD) |=> $stable(pc_o));

endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 20;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] imm;
        logic        sg;
        logic [11:0] exp;
        logic [7:0]  req;
    } vec_t;

    // op, opa, opb, imm, sign in, expected pc, requirement number
    localparam vec_t VECS [0:N_VEC-1] = '{
        '{4'd0,  16'h0000, 16'h0000, 16'h0000, 1'b0, 12'h001, 8'd2},  // R2 advance
        '{4'd0,  16'h0000, 16'h0000, 16'h0000, 1'b0, 12'h002, 8'd2},  // R2
        '{4'd4,  16'h0000, 16'h0000, 16'hF123, 1'b0, 12'h123, 8'd3},  // R3 imm, upper dropped
        '{4'd3,  16'hA456, 16'h0000, 16'h0000, 1'b0, 12'h456, 8'd3},  // R3 reg, upper dropped
        '{4'd5,  16'h0005, 16'h0005, 16'h0200, 1'b0, 12'h200, 8'd4},  // R4 equal
        '{4'd5,  16'h1005, 16'h0005, 16'h0300, 1'b0, 12'h201, 8'd4},  // R4 differs above bit 11
        '{4'd7,  16'h0000, 16'h0000, 16'h0050, 1'b0, 12'h050, 8'd5},  // R5 reset sign positive
        '{4'd1,  16'h0000, 16'h0000, 16'h0000, 1'b1, 12'h051, 8'd6},  // R6 capture negative
        '{4'd7,  16'h0000, 16'h0000, 16'h0400, 1'b0, 12'h052, 8'd5},  // R5 positive not taken
        '{4'd9,  16'h0000, 16'h0000, 16'h0400, 1'b0, 12'h400, 8'd5},  // R5 negative imm
        '{4'd2,  16'h0000, 16'h0000, 16'h0000, 1'b0, 12'h401, 8'd6},  // R6 logic ignored
        '{4'd8,  16'h0ABC, 16'h0000, 16'h0000, 1'b0, 12'hABC, 8'd5},  // R5/R6 still negative
        '{4'd1,  16'h0000, 16'h0000, 16'h0000, 1'b0, 12'hABD, 8'd6},  // R6 capture zero/positive
        '{4'd9,  16'h0000, 16'h0000, 16'h0111, 1'b0, 12'hABE, 8'd5},  // R5 negative not taken
        '{4'd6,  16'hF7FF, 16'h0000, 16'h0000, 1'b0, 12'h7FF, 8'd5},  // R5 positive reg
        '{4'd13, 16'h0000, 16'h0000, 16'h0123, 1'b0, 12'h7FF, 8'd10}, // R10 hold
        '{4'd4,  16'h0000, 16'h0000, 16'h0FFF, 1'b0, 12'hFFF, 8'd3},  // R3
        '{4'd0,  16'h0000, 16'h0000, 16'h0000, 1'b0, 12'h000, 8'd2},  // R2 wrap
        '{4'd2,  16'h0000, 16'h0000, 16'h0000, 1'b1, 12'h001, 8'd6},  // R6 logic ignored
        '{4'd7,  16'h0000, 16'h0000, 16'h00AA, 1'b0, 12'h0AA, 8'd6}   // R6 sign stayed positive
    };

    logic        clk;
    logic        rst_n;
    logic [3:0]  op;
    logic [15:0] opa;
    logic [15:0] opb;
    logic [15:0] imm;
    logic        rsign;
    logic [11:0] pc;
    logic        busy;

    int n_checks;
    int n_fail;
    logic busy_seen;

    pc_sequencer u_pc_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .opa_i      (opa),
        .opb_i      (opb),
        .imm_i      (imm),
        .res_sign_i (rsign),
        .pc_o       (pc),
        .busy_o     (busy)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Drive at a falling edge, sample busy, then wait one full cycle.
    task automatic apply(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] i, input logic s);
        op    = o;
        opa   = a;
        opb   = b;
        imm   = i;
        rsign = s;
        #1;
        busy_seen = busy;
        @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        n_checks = 0;
        n_fail   = 0;
        rst_n = 1'b0;
        op = 4'd0; opa = '0; opb = '0; imm = '0; rsign = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pc", 16'(pc), 16'h000);
        check("R1 busy", 16'(busy), 16'h0);
        rst_n = 1'b1;

        for (int k = 0; k < N_VEC; k++) begin
            apply(VECS[k].op, VECS[k].a, VECS[k].b, VECS[k].imm, VECS[k].sg);
            n_checks++;
            if (pc !== VECS[k].exp || busy_seen !== 1'b0) begin
                n_fail++;
                $display("FAIL R%0d row %0d actual=%h expected=%h busy=%b",
                         VECS[k].req, k, pc, VECS[k].exp, busy_seen);
            end
        end

        // R1/R8: return with no call since reset goes to 0
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(4'd0, '0, '0, '0, 1'b0);
        apply(4'd0, '0, '0, '0, 1'b0);
        apply(4'd0, '0, '0, '0, 1'b0);
        check("R2 pre-return", 16'(pc), 16'h003);
        apply(4'd12, '0, '0, '0, 1'b0);
        check("R8 return busy", 16'(busy_seen), 16'h1);
        check("R8 return holds", 16'(pc), 16'h003);
        apply(4'd0, '0, '0, '0, 1'b0);
        check("R1 empty link", 16'(pc), 16'h000);

        // R7: immediate call, conflicting jump ignored in second cycle
        apply(4'd4, '0, '0, 16'h0100, 1'b0);
        apply(4'd11, '0, '0, 16'h0345, 1'b0);
        check("R7 call busy", 16'(busy_seen), 16'h1);
        check("R7 call holds", 16'(pc), 16'h100);
        apply(4'd4, '0, '0, 16'h0777, 1'b0);
        check("R7 second not busy", 16'(busy_seen), 16'h0);
        check("R7 call target", 16'(pc), 16'h345);
        apply(4'd12, '0, '0, '0, 1'b0);
        apply(4'd0, '0, '0, '0, 1'b0);
        check("R8 return to call+1", 16'(pc), 16'h101);

        // R9: nested calls, the second overwrites the link
        apply(4'd10, 16'hF200, '0, '0, 1'b0);
        apply(4'd0, '0, '0, '0, 1'b0);
        check("R7 reg call target", 16'(pc), 16'h200);
        apply(4'd11, '0, '0, 16'h0300, 1'b0);
        apply(4'd0, '0, '0, '0, 1'b0);
        check("R9 inner call", 16'(pc), 16'h300);
        apply(4'd12, '0, '0, '0, 1'b0);
        apply(4'd0, '0, '0, '0, 1'b0);
        check("R9 single link", 16'(pc), 16'h201);

        report();
    end

endmodule